// File: doc/BRIEF.md
# Two-Channel DAC Parallel Write Sequencer

This block feeds a two-channel, 14-bit current-output DAC through its parallel pins. Each DAC channel takes one stream of samples over a valid/ready handshake. The DAC has two latch stages. A word enters an input latch on a rising write strobe, and it moves to the DAC latch, and so to the analog output, on a rising latch strobe. The block generates that sequence of strobes and keeps the data stable around every write edge.

A static mode input selects one of two pin schemes. In dual-port mode, each channel has its own data bus, write strobe and latch strobe. Both channels update together once every two clocks. In interleaved mode, one shared bus carries both channels in turn. Channel A's write and latch pins act as the shared write and the shared latch clock. Channel B's write pin acts as the channel select, and channel B's latch pin acts as the latch reset. Each channel then updates once every four clocks.

A change on the mode input takes effect only at the end of an output frame. The block then holds the strobes in a safe state for a settle window before it sends new data. A channel whose stream has no sample ready when its slot comes keeps repeating its last word. The other channel is not held back.

Top module: `dac_if_drv`

## Requirements
- R1: With `mode_i`=0 (dual-port), each channel drives its word on its own bus. The write and latch strobes of a channel rise together in the same cycle. A rising strobe pair occurs once every two clocks.
- R2: On every rising `pa_wstb`, `pa_data` holds the same value as in the cycle before. In dual-port mode the same holds for `pb_data` on a rising `pb_wstb`. In interleaved mode the select pin `pb_wstb` is also unchanged from the cycle before.
- R3: A latch strobe never rises before its write. In dual-port mode, each rising latch strobe comes with or after a write of that channel since the previous latch edge. In interleaved mode, each rising `pa_lstb` comes after writes to both channels since the previous latch edge.
- R4: With `mode_i`=1 (interleaved), the word on `pa_data` goes to channel A when `pb_wstb` is 1 at the rising `pa_wstb`, and to channel B when `pb_wstb` is 0. `pa_wstb` rises every two clocks, and `pa_lstb` rises every four clocks, in the same cycle as the channel B write. When a write edge and a latch edge fall in the same cycle, the write takes effect first.
- R5: In interleaved mode, `pb_lstb` acts as the latch reset. It is 1 throughout the settle window and 0 in the first cycle after it. `pa_lstb` is never 1 while `pb_lstb` is 1.
- R6: In interleaved mode, `pb_data` is held at all zeros.
- R7: The block compares `mode_i` with the active mode only at the end of a frame. If they differ, two settle cycles follow. In dual-port mode all four strobes stay low during these cycles. In interleaved mode the latch reset is high and both shared strobes are low. The same window follows reset.
- R8: When a channel's `valid` is low in its fetch cycle (`ready`=1), that channel's next output update repeats its previous word. The other channel keeps taking new words.
- R9: A word is accepted when `valid` and `ready` are both 1 at a rising clock edge. The sequence of DAC-latch values for each channel equals that channel's accepted words in order, with repeats inserted per R8.
- R10: While `rst_n` is low, both `ready` outputs, all strobes and both buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0 selects dual-port, 1 selects interleaved |
| sa_valid | input | 1 | Channel A sample valid |
| sa_data | input | 14 | Channel A sample word |
| sa_ready | output | 1 | Channel A fetch slot |
| sb_valid | input | 1 | Channel B sample valid |
| sb_data | input | 14 | Channel B sample word |
| sb_ready | output | 1 | Channel B fetch slot |
| pa_data | output | 14 | Channel A bus (shared bus in interleaved mode) |
| pb_data | output | 14 | Channel B bus (zero in interleaved mode) |
| pa_wstb | output | 1 | Channel A write (shared write) |
| pa_lstb | output | 1 | Channel A latch strobe (shared latch clock) |
| pb_wstb | output | 1 | Channel B write (channel select) |
| pb_lstb | output | 1 | Channel B latch strobe (latch reset) |

## Verification
In interleaved mode, the channel B write edge and the shared latch clock edge occur in the same cycle. A DAC model that applies the write before the latch decides whether channel B's output carries the word just written or the stale one. The scoreboard compares every latch update against the queued accepted words. A second coincidence comes from changing `mode_i` while streams are running, so the request lands on a frame-end cycle that would otherwise also be a fetch slot. The bench then expects that fetch to be withheld, the settle signature to appear for exactly two cycles, and no queued word to be lost or duplicated across the switch.

// File: rtl/dacdrv_pkg.sv
// Shared types for the two-channel DAC write sequencer.
package dacdrv_pkg;
    typedef enum logic {
        MODE_DUAL = 1'b0,
        MODE_ILV  = 1'b1
    } dac_mode_e;

    typedef enum logic {
        ST_SETTLE = 1'b0,
        ST_RUN    = 1'b1
    } seq_state_e;

    localparam int unsigned NCH = 2;
endpackage

// File: rtl/dacdrv_seq.sv
// Frame sequencer: holds the active mode, the frame phase and the settle
// window, and decides which channel fetches a sample in which cycle.
// Assumes mode_i is quasi-static; it is compared only at a frame end.
module dacdrv_seq
    import dacdrv_pkg::*;
#(
    parameter int SETTLE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_i,
    output logic       run_o,
    output logic       ilv_o,
    output logic [1:0] ph_o,
    output logic [1:0] fetch_o
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    seq_state_e   st_q;
    dac_mode_e    mode_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]   ph_q;
    logic         run, ilv, frame_end, sw_req, settle_last;

    // Frame-end, switch-request and fetch-slot decode.
    always_comb begin
        run         = (st_q == ST_RUN);
        ilv         = (mode_q == MODE_ILV);
        frame_end   = run && (ilv ? (ph_q == 2'd3) : (ph_q == 2'd1));
        sw_req      = frame_end && (dac_mode_e'(mode_i) != mode_q);
        settle_last = (st_q == ST_SETTLE) && (cnt_q == CW'(SETTLE_CYC - 1));
        fetch_o[0]  = settle_last || (frame_end && !sw_req);
        fetch_o[1]  = (settle_last && !ilv) || (frame_end && !sw_req && !ilv)
                    || (run && ilv && ph_q == 2'd1);
    end

    // State, settle counter, phase and active-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_SETTLE;
            cnt_q  <= '0;
            ph_q   <= 2'd0;
            mode_q <= dac_mode_e'(mode_i);
        end else if (st_q == ST_SETTLE) begin
            if (settle_last) begin
                st_q  <= ST_RUN;
                cnt_q <= '0;
                ph_q  <= 2'd0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end else if (sw_req) begin
            st_q   <= ST_SETTLE;
            cnt_q  <= '0;
            ph_q   <= 2'd0;
            mode_q <= dac_mode_e'(mode_i);
        end else begin
            ph_q <= ilv ? ph_q + 2'd1 : {1'b0, ~ph_q[0]};
        end
    end

    assign run_o = run;
    assign ilv_o = ilv;
    assign ph_o  = ph_q;

    // R7: the active mode moves only right after a frame end.
    a_r7_mode_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> $past(frame_end));

    // R7: running resumes only after the full settle count.
    a_r7_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> ($past(cnt_q) == CW'(SETTLE_CYC - 1)));
endmodule

// File: rtl/dacdrv_hold.sv
// Per-channel sample holder: takes a word when its slot and valid coincide,
// otherwise keeps the previous word so the channel repeats it.
module dacdrv_hold #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_i,
    input  logic          valid_i,
    input  logic [DW-1:0] data_i,
    output logic          ready_o,
    output logic [DW-1:0] word_o
);
    logic [DW-1:0] word_q;

    // Capture a new word on a handshake, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                 word_q <= '0;
        else if (fetch_i && valid_i) word_q <= data_i;
    end

    assign ready_o = fetch_i;
    assign word_o  = word_q;

    // R8: without a handshake the held word does not change.
    a_r8_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_i && valid_i) |=> $stable(word_q));

    // R9: a handshake loads exactly the offered word.
    a_r9_hold_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && valid_i) |=> (word_q == $past(data_i)));
endmodule

// File: rtl/dacdrv_pins.sv
// Pin decoder: maps mode, phase and held words onto the six DAC-side
// outputs and registers them, so every pin changes only at a clock edge.
// Assumes ph_i counts 0..1 in dual-port and 0..3 in interleaved mode.
module dacdrv_pins #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          ilv_i,
    input  logic [1:0]    ph_i,
    input  logic [DW-1:0] word_a_i,
    input  logic [DW-1:0] word_b_i,
    output logic [DW-1:0] pa_data,
    output logic [DW-1:0] pb_data,
    output logic          pa_wstb,
    output logic          pa_lstb,
    output logic          pb_wstb,
    output logic          pb_lstb
);
    logic [DW-1:0] n_da, n_db;
    logic          n_wa, n_ka, n_wb, n_kb;
    logic          ilv_q;

    // Next pin values for the current mode and phase.
    always_comb begin
        n_da = word_a_i;
        n_db = word_b_i;
        n_wa = 1'b0;
        n_ka = 1'b0;
        n_wb = 1'b0;
        n_kb = 1'b0;
        if (ilv_i) begin
            n_db = '0;
            n_da = ph_i[1] ? word_b_i : word_a_i;
            if (run_i) begin
                n_wa = ph_i[0];
                n_ka = (ph_i == 2'd3);
                n_wb = ~ph_i[1];
            end else begin
                n_wb = 1'b1;
                n_kb = 1'b1;
            end
        end else if (run_i) begin
            n_wa = ph_i[0];
            n_ka = ph_i[0];
            n_wb = ph_i[0];
            n_kb = ph_i[0];
        end
    end

    // Output registers, plus the mode aligned with them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_data <= '0;
            pb_data <= '0;
            pa_wstb <= 1'b0;
            pa_lstb <= 1'b0;
            pb_wstb <= 1'b0;
            pb_lstb <= 1'b0;
            ilv_q   <= 1'b0;
        end else begin
            pa_data <= n_da;
            pb_data <= n_db;
            pa_wstb <= n_wa;
            pa_lstb <= n_ka;
            pb_wstb <= n_wb;
            pb_lstb <= n_kb;
            ilv_q   <= ilv_i;
        end
    end

    // R2: bus A is settled one cycle ahead of its write edge.
    a_r2_bus_a_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pa_wstb) |-> (pa_data == $past(pa_data)));

    // R4: the channel select is settled ahead of the shared write.
    a_r4_sel_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (ilv_q && $rose(pa_wstb)) |-> $stable(pb_wstb));

    // R6: bus B is all zeros in interleaved mode.
    a_r6_bus_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ilv_q |-> (pb_data == '0));

    // R5: no latch clock while the latch reset is high.
    a_r5_latch_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ilv_q && pb_lstb) |-> !pa_lstb);

    // R3: in dual-port mode the latch edge never leads the write edge.
    a_r3_latch_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!ilv_q && $rose(pa_lstb)) |-> $rose(pa_wstb));
endmodule

// File: rtl/dac_if_drv.sv
// Top: two-channel DAC write sequencer. Takes one valid/ready stream per
// channel and drives the DAC data and strobe pins in dual-port or
// interleaved mode. Assumes mode_i changes rarely; it is sampled at frame ends.
module dac_if_drv
    import dacdrv_pkg::*;
#(
    parameter int DW         = 14,
    parameter int SETTLE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          sa_valid,
    input  logic [DW-1:0] sa_data,
    output logic          sa_ready,
    input  logic          sb_valid,
    input  logic [DW-1:0] sb_data,
    output logic          sb_ready,
    output logic [DW-1:0] pa_data,
    output logic [DW-1:0] pb_data,
    output logic          pa_wstb,
    output logic          pa_lstb,
    output logic          pb_wstb,
    output logic          pb_lstb
);
    logic          run, ilv;
    logic [1:0]    ph;
    logic [NCH-1:0] fetch, s_valid, s_ready;
    logic [DW-1:0] s_data [NCH];
    logic [DW-1:0] word   [NCH];

    assign s_valid  = {sb_valid, sa_valid};
    assign s_data[0] = sa_data;
    assign s_data[1] = sb_data;
    assign sa_ready = s_ready[0];
    assign sb_ready = s_ready[1];

    dacdrv_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .run_o   (run),
        .ilv_o   (ilv),
        .ph_o    (ph),
        .fetch_o (fetch)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dacdrv_hold #(.DW(DW)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .fetch_i (fetch[c]),
            .valid_i (s_valid[c]),
            .data_i  (s_data[c]),
            .ready_o (s_ready[c]),
            .word_o  (word[c])
        );
    end

    dacdrv_pins #(.DW(DW)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .ilv_i    (ilv),
        .ph_i     (ph),
        .word_a_i (word[0]),
        .word_b_i (word[1]),
        .pa_data  (pa_data),
        .pb_data  (pb_data),
        .pa_wstb  (pa_wstb),
        .pa_lstb  (pa_lstb),
        .pb_wstb  (pb_wstb),
        .pb_lstb  (pb_lstb)
    );
endmodule

// File: tb/dac_if_drv_test.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver pushes the expected word of every fetch slot,
// and a two-stage DAC model pops and compares on every latch update.
module dac_if_drv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0;
    logic        sa_valid = 1'b0, sb_valid = 1'b0;
    logic [13:0] sa_data = '0, sb_data = '0;
    logic        sa_ready, sb_ready;
    logic [13:0] pa_data, pb_data;
    logic        pa_wstb, pa_lstb, pb_wstb, pb_lstb;

    dac_if_drv uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .sa_valid(sa_valid), .sa_data(sa_data), .sa_ready(sa_ready),
        .sb_valid(sb_valid), .sb_data(sb_data), .sb_ready(sb_ready),
        .pa_data(pa_data), .pb_data(pb_data),
        .pa_wstb(pa_wstb), .pa_lstb(pa_lstb), .pb_wstb(pb_wstb), .pb_lstb(pb_lstb)
    );

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Stimulus controls written by the sequence, applied by the step process.
    bit          want_mode = 0, en_a = 0, en_b = 0, gap_a = 0, gap_b = 0;
    logic [13:0] src_a[$], src_b[$];
    logic [14:0] q_a[$], q_b[$];           // bit 14 marks a repeat
    logic [13:0] last_a = '0, last_b = '0;
    int          slot_a = 0, slot_b = 0, upd_a = 0, upd_b = 0, reps = 0, settle_seen = 0;

    // DAC model state.
    bit          mode_m = 0;
    int          settle_left = 3;
    logic [13:0] in_a = '0, in_b = '0, p_da = '0, p_db = '0;
    bit          pend_a = 0, pend_b = 0;
    bit          p_wa = 0, p_ka = 0, p_wb = 0, p_kb = 0;

    task automatic pop_cmp(input bit chan, input logic [13:0] val);
        logic [14:0] e;
        if (chan == 0) begin
            if (q_a.size() == 0) begin chk(0, "R9 ch A update without fetch", val, 0); return; end
            e = q_a.pop_front(); upd_a++;
            chk(val == e[13:0], e[14] ? "R8 ch A repeat" : "R9 ch A word", val, e[13:0]);
        end else begin
            if (q_b.size() == 0) begin chk(0, "R9 ch B update without fetch", val, 0); return; end
            e = q_b.pop_front(); upd_b++;
            chk(val == e[13:0], e[14] ? "R8 ch B repeat" : "R9 ch B word", val, e[13:0]);
        end
    endtask

    // Per-cycle step: monitor pins, follow the mode, then drive and score fetches.
    always @(negedge clk) begin
        bit r_wa, r_ka, r_wb, r_kb, fe;
        logic [14:0] e;
        r_wa = pa_wstb & ~p_wa; r_ka = pa_lstb & ~p_ka;
        r_wb = pb_wstb & ~p_wb; r_kb = pb_lstb & ~p_kb;
        if (rst_n) begin
            if (settle_left == 3 || settle_left == 2) begin
                settle_seen++;
                if (mode_m) chk(pb_lstb && !pa_wstb && !pa_lstb, "R5 R7 interleaved settle pins",
                                {pb_lstb, pa_wstb, pa_lstb}, 3'b100);
                else        chk(!pa_wstb && !pa_lstb && !pb_wstb && !pb_lstb, "R7 dual settle strobes low",
                                {pa_wstb, pa_lstb, pb_wstb, pb_lstb}, 0);
            end else if (settle_left == 1 && mode_m) begin
                chk(!pb_lstb, "R5 latch reset low after settle", pb_lstb, 0);
            end
            if (settle_left > 0) settle_left--;
            if (!mode_m) begin
                chk(pa_wstb == pa_lstb && pb_wstb == pb_lstb, "R1 strobes rise together",
                    {pa_wstb, pa_lstb, pb_wstb, pb_lstb}, {pa_wstb, pa_wstb, pb_wstb, pb_wstb});
                if (r_wa) begin chk(pa_data == p_da, "R2 bus A setup", pa_data, p_da); in_a = pa_data; pend_a = 1; end
                if (r_wb) begin chk(pb_data == p_db, "R2 bus B setup", pb_data, p_db); in_b = pb_data; pend_b = 1; end
                if (r_ka) begin chk(pend_a, "R3 latch A before write", 0, 1); pend_a = 0; pop_cmp(0, in_a); end
                if (r_kb) begin chk(pend_b, "R3 latch B before write", 0, 1); pend_b = 0; pop_cmp(1, in_b); end
            end else begin
                chk(pb_data == 0, "R6 bus B zero", pb_data, 0);
                chk(!(pb_lstb && pa_lstb), "R5 latch clock under reset", pa_lstb, 0);
                if (r_wa) begin
                    chk(pa_data == p_da && pb_wstb == p_wb, "R2 shared bus/select setup",
                        {pb_wstb, pa_data}, {p_wb, p_da});
                    if (pb_wstb) begin in_a = pa_data; pend_a = 1; end
                    else         begin in_b = pa_data; pend_b = 1; end
                end
                if (r_ka && !pb_lstb) begin
                    chk(pend_a && pend_b, "R3 R4 latch before both writes", {pend_a, pend_b}, 2'b11);
                    pend_a = 0; pend_b = 0;
                    pop_cmp(0, in_a);
                    pop_cmp(1, in_b);
                end
            end
            fe = mode_m ? pa_lstb : pa_wstb;
            if (fe && (mode_i != mode_m)) begin
                mode_m = mode_i; settle_left = 3; pend_a = 0; pend_b = 0;
            end
        end
        p_wa = pa_wstb; p_ka = pa_lstb; p_wb = pb_wstb; p_kb = pb_lstb;
        p_da = pa_data; p_db = pb_data;
        // Drive the inputs for the coming edge.
        mode_i   = want_mode;
        sa_valid = en_a && src_a.size() > 0 && !(gap_a && (slot_a % 3 == 2));
        sb_valid = en_b && src_b.size() > 0 && !(gap_b && (slot_b % 3 == 2));
        sa_data  = (src_a.size() > 0) ? src_a[0] : 14'h0;
        sb_data  = (src_b.size() > 0) ? src_b[0] : 14'h0;
        #1;
        if (rst_n && sa_ready) begin
            e = sa_valid ? {1'b0, sa_data} : {1'b1, last_a};
            if (sa_valid) void'(src_a.pop_front()); else reps++;
            last_a = e[13:0]; q_a.push_back(e); slot_a++;
        end
        if (rst_n && sb_ready) begin
            e = sb_valid ? {1'b0, sb_data} : {1'b1, last_b};
            if (sb_valid) void'(src_b.pop_front()); else reps++;
            last_b = e[13:0]; q_b.push_back(e); slot_b++;
        end
    end

    task automatic fill(input int n, input int base_a, input int base_b);
        for (int i = 0; i < n; i++) begin
            src_a.push_back(14'(base_a + i * 37));
            src_b.push_back(14'(base_b + i * 101));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1.5;
        // R10: reset state at the ports.
        chk(sa_ready == 0 && sb_ready == 0, "R10 ready low in reset", {sa_ready, sb_ready}, 0);
        chk(!pa_wstb && !pa_lstb && !pb_wstb && !pb_lstb, "R10 strobes low in reset",
            {pa_wstb, pa_lstb, pb_wstb, pb_lstb}, 0);
        chk(pa_data == 0 && pb_data == 0, "R10 buses zero in reset", pa_data | pb_data, 0);
        rst_n = 1'b1;
        // Dual-port, channel B with gaps.
        fill(24, 14'h0100, 14'h2000);
        en_a = 1; en_b = 1; gap_b = 1;
        repeat (80) @(posedge clk);
        // Switch to interleaved while streaming, channel A with gaps.
        fill(24, 14'h1200, 14'h3300);
        want_mode = 1; gap_a = 1; gap_b = 0;
        repeat (150) @(posedge clk);
        en_a = 0;
        repeat (40) @(posedge clk);
        en_a = 1; gap_a = 0;
        repeat (60) @(posedge clk);
        // Back to dual-port.
        fill(16, 14'h0a00, 14'h1c00);
        want_mode = 0;
        repeat (120) @(posedge clk);
        en_a = 0; en_b = 0;
        repeat (20) @(posedge clk);
        @(negedge clk); #1.5;
        chk(src_a.size() == 0 && src_b.size() == 0, "R9 all offered words accepted",
            src_a.size() + src_b.size(), 0);
        chk(upd_a >= 64 && upd_b >= 64, "R9 all accepted words reached the latch", upd_a, 64);
        chk(reps > 0, "R8 repeats exercised", reps, 1);
        chk(settle_seen == 6, "R7 settle cycles after reset and two switches", settle_seen, 6);
        chk(mode_m == 0, "R7 final mode followed", mode_m, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule